// File: doc/BRIEF.md
# SD/MMC Host Interrupt Status Unit

This unit collects the one-cycle event pulses produced inside an SD/MMC host controller and turns them into sticky status flags for software. Each event has a fixed bit in a 32-bit raw status word. A flag stays set until software writes a 1 to its bit. A mask word chosen by software decides which raw flags appear in the masked status word and drive the interrupt line.

Software can also poll two summary outputs without touching the mask. The error summary reports any pending fault. The completion summary reports any finished command or transfer. Everything is reached through a simple register port: a write strobe with an address and data, and registered read data that follows the address one cycle later.

Bit map, used by every requirement below:
- 1: response error
- 2: command done
- 3: data over
- 4: TX data request
- 5: RX data request
- 6: response CRC error
- 7: data CRC error
- 8: response timeout
- 9: data timeout
- 10: voltage switch done
- 11: FIFO under/overrun
- 12: hardware locked
- 13: start bit error
- 14: auto command done
- 15: end bit error
- 16: SDIO interrupt
- 30: card insert
- 31: card remove

All other bits (0 and 17 to 29) are unassigned. The implemented-bit word is 0xC001FFFE. Register offsets are: mask 0x30, masked status 0x34, raw status 0x38.

Top module: `sdhost_irq_status`

## Requirements
- R1: After synchronous reset, the raw status, mask, masked status, read data, both summaries and the interrupt line are all zero.
- R2: A 1 on an implemented bit of `evt_i` sets that raw status bit at the next clock edge. The bit stays set after the pulse ends.
- R3: A write to offset 0x38 clears exactly the raw bits written as 1 and leaves all other raw bits unchanged. Writing 0xFFFFFFFF clears every bit.
- R4: When an event pulse and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R5: Unassigned bits (0 and 17 to 29) never become set from events and always read as zero.
- R6: A write to offset 0x30 loads the mask. Reading offset 0x30 returns the written value AND 0xC001FFFE.
- R7: The masked status equals raw AND mask. It is readable at offset 0x34, and writes to offset 0x34 change neither raw status nor mask.
- R8: `irq_o` is the OR of all masked status bits. It and `masked_o` follow `raw_o` by one cycle.
- R9: `err_sum_o` is the OR of the raw bits selected by 0xBFC2, whatever the mask. It follows `raw_o` by one cycle.
- R10: `done_sum_o` is the OR of raw bits 2, 3, 10 and 14, whatever the mask. It follows `raw_o` by one cycle.
- R11: `reg_rdata` shows the register addressed in the previous cycle. Offsets other than 0x30, 0x34 and 0x38 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | One-cycle event pulses, one per raw bit position |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| raw_o | output | 32 | Raw sticky status |
| masked_o | output | 32 | Raw status AND mask, registered |
| err_sum_o | output | 1 | Error summary, registered |
| done_sum_o | output | 1 | Completion summary, registered |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The hardest case to reach from the ports is a clearing write and a new event landing on the same bit in the same cycle. The stimulus sets a bit first, then in one cycle drives both the write strobe at 0x38 and the event pulse on that bit. It also clears a neighbouring bit in the same write, which shows the clear itself took effect. The unassigned bits are covered by pulsing every one of them together and by writing all ones to the mask. The summaries are separated from each other with single events that belong to only one of the two groups.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
  localparam int unsigned STAT_W = 32;
  typedef logic [STAT_W-1:0] stat_t;

  localparam int unsigned B_RESP_ERR  = 1;
  localparam int unsigned B_CMD_DONE  = 2;
  localparam int unsigned B_DATA_OVER = 3;
  localparam int unsigned B_TX_REQ    = 4;
  localparam int unsigned B_RX_REQ    = 5;
  localparam int unsigned B_RESP_CRC  = 6;
  localparam int unsigned B_DATA_CRC  = 7;
  localparam int unsigned B_RESP_TO   = 8;
  localparam int unsigned B_DATA_TO   = 9;
  localparam int unsigned B_VSW_DONE  = 10;
  localparam int unsigned B_FIFO_RUN  = 11;
  localparam int unsigned B_HW_LOCK   = 12;
  localparam int unsigned B_START_ERR = 13;
  localparam int unsigned B_ACMD_DONE = 14;
  localparam int unsigned B_END_ERR   = 15;
  localparam int unsigned B_SDIO      = 16;
  localparam int unsigned B_CARD_IN   = 30;
  localparam int unsigned B_CARD_OUT  = 31;

  // Bits that hold a status flag; all others are tied to zero.
  localparam stat_t IMPL_BITS = stat_t'(32'h0001_FFFE) | (stat_t'(1) << B_CARD_IN)
                              | (stat_t'(1) << B_CARD_OUT);

  // Fault flags folded into the error summary (evaluates to 0xBFC2).
  localparam stat_t ERR_BITS =
      (stat_t'(1) << B_RESP_ERR)  | (stat_t'(1) << B_RESP_CRC) |
      (stat_t'(1) << B_DATA_CRC)  | (stat_t'(1) << B_RESP_TO)  |
      (stat_t'(1) << B_DATA_TO)   | (stat_t'(1) << B_VSW_DONE) |
      (stat_t'(1) << B_FIFO_RUN)  | (stat_t'(1) << B_HW_LOCK)  |
      (stat_t'(1) << B_START_ERR) | (stat_t'(1) << B_END_ERR);

  // Completion flags folded into the done summary.
  localparam stat_t DONE_BITS =
      (stat_t'(1) << B_CMD_DONE) | (stat_t'(1) << B_DATA_OVER) |
      (stat_t'(1) << B_VSW_DONE) | (stat_t'(1) << B_ACMD_DONE);
endpackage

// File: rtl/sdirq_raw_bank.sv
module sdirq_raw_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] raw_q;

  // One sticky flop per bit; a new event outranks a clear.
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) raw_q[i] <= 1'b0;
      else     raw_q[i] <= IMPL[i] & (evt_i[i] | (raw_q[i] & ~clr_i[i]));
    end
  end

  assign raw_o = raw_q;

  // R2 / R3: bits that were set and not cleared stay set
  p_hold_uncleared_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & $past(raw_q & ~clr_i)) == $past(raw_q & ~clr_i)));

  // R4: an event lands even under a simultaneous clear
  p_event_wins_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));

  // R3: a cleared bit with no event drops
  p_clear_takes_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & $past(clr_i & ~evt_i)) == '0));

  // R5: unassigned positions never hold a flag
  p_unused_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (raw_q & ~IMPL) == '0);
endmodule

// File: rtl/sdirq_regport.sv
module sdirq_regport #(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [W-1:0] IMPL  = '1,
  parameter logic [ADDR_W-1:0] OFS_MASK  = 8'h30,
  parameter logic [ADDR_W-1:0] OFS_MSTAT = 8'h34,
  parameter logic [ADDR_W-1:0] OFS_RAW   = 8'h38
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      raw_i,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      clr_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] rdata_q;
  logic         hit_mask, hit_raw;

  assign hit_mask = wr_i && (addr_i == OFS_MASK);
  assign hit_raw  = wr_i && (addr_i == OFS_RAW);
  assign clr_o    = hit_raw ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst)           mask_q <= '0;
    else if (hit_mask) mask_q <= wdata_i & IMPL;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (addr_i)
        OFS_MASK:  rdata_q <= mask_q;
        OFS_MSTAT: rdata_q <= raw_i & mask_q;
        OFS_RAW:   rdata_q <= raw_i;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;

  // R6: mask only holds implemented bits
  p_mask_impl_r6: assert property (@(posedge clk) disable iff (rst)
    (mask_q & ~IMPL) == '0);

  // R7: mask is untouched by writes elsewhere
  p_mask_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !hit_mask |=> $stable(mask_q));

  // R11: unmapped offsets read zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (addr_i != OFS_MASK && addr_i != OFS_MSTAT && addr_i != OFS_RAW)
      |=> rdata_q == '0);
endmodule

// File: rtl/sdirq_summary.sv
module sdirq_summary #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] ERR  = '0,
  parameter logic [W-1:0] DONE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] masked_o,
  output logic         irq_o,
  output logic         err_o,
  output logic         done_o
);
  logic [W-1:0] masked_q;
  logic         irq_q, err_q, done_q;
  logic [W-1:0] masked_d;

  assign masked_d = raw_i & mask_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      masked_q <= '0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      masked_q <= masked_d;
      irq_q    <= |masked_d;
      err_q    <= |(raw_i & ERR);
      done_q   <= |(raw_i & DONE);
    end
  end

  assign masked_o = masked_q;
  assign irq_o    = irq_q;
  assign err_o    = err_q;
  assign done_o   = done_q;

  // R8: interrupt line agrees with the masked word
  p_irq_matches_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q == (masked_q != '0));

  // R7: masked word never shows an unmasked or clear bit
  p_masked_subset_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((masked_q & ~$past(raw_i & mask_i)) == '0));

  // R9: any pending fault raises the error summary
  p_err_follows_r9: assert property (@(posedge clk) disable iff (rst)
    ((raw_i & ERR) != '0) |=> err_q);

  // R10: any completion raises the done summary
  p_done_follows_r10: assert property (@(posedge clk) disable iff (rst)
    ((raw_i & DONE) != '0) |=> done_q);
endmodule

// File: rtl/sdhost_irq_status.sv
module sdhost_irq_status
  import sdirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_MASK  = 8'h30,
  parameter logic [ADDR_W-1:0] OFS_MSTAT = 8'h34,
  parameter logic [ADDR_W-1:0] OFS_RAW   = 8'h38
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       evt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [31:0]       raw_o,
  output logic [31:0]       masked_o,
  output logic              err_sum_o,
  output logic              done_sum_o,
  output logic              irq_o
);
  stat_t raw_w, mask_w, clr_w;

  sdirq_regport #(
    .W(STAT_W), .ADDR_W(ADDR_W), .IMPL(IMPL_BITS),
    .OFS_MASK(OFS_MASK), .OFS_MSTAT(OFS_MSTAT), .OFS_RAW(OFS_RAW)
  ) u_port (
    .clk(clk), .rst(rst), .addr_i(reg_addr), .wr_i(reg_wr),
    .wdata_i(reg_wdata), .raw_i(raw_w), .mask_o(mask_w),
    .clr_o(clr_w), .rdata_o(reg_rdata)
  );

  sdirq_raw_bank #(.W(STAT_W), .IMPL(IMPL_BITS)) u_raw (
    .clk(clk), .rst(rst), .evt_i(evt_i), .clr_i(clr_w), .raw_o(raw_w)
  );

  sdirq_summary #(.W(STAT_W), .ERR(ERR_BITS), .DONE(DONE_BITS)) u_sum (
    .clk(clk), .rst(rst), .raw_i(raw_w), .mask_i(mask_w),
    .masked_o(masked_o), .irq_o(irq_o), .err_o(err_sum_o), .done_o(done_sum_o)
  );

  assign raw_o = raw_w;
endmodule

// File: tb/sim_sdhost_irq_status.sv
`timescale 1ns/1ps
module sim_sdhost_irq_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt_i = '0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, raw_o, masked_o;
  logic        err_sum_o, done_sum_o, irq_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] rv;

  localparam logic [31:0] IMPL = 32'hC001_FFFE;

  always #2 clk = ~clk;

  sdhost_irq_status u0 (
    .clk(clk), .rst(rst), .evt_i(evt_i), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .raw_o(raw_o),
    .masked_o(masked_o), .err_sum_o(err_sum_o), .done_sum_o(done_sum_o),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); evt_i = v;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 raw", raw_o, '0);
    check("R1 masked", masked_o, '0);
    check("R1 rdata", reg_rdata, '0);
    check("R1 sums/irq", {29'd0, err_sum_o, done_sum_o, irq_o}, '0);
    rd(8'h30, rv); check("R1 mask", rv, '0);
  endtask

  task automatic t_sticky();
    pulse(32'h0000_0004);
    check("R2 set", raw_o, 32'h0000_0004);
    settle(); settle();
    check("R2 held", raw_o, 32'h0000_0004);
    pulse(32'h8000_0200);
    check("R2 accumulate", raw_o, 32'h8000_0204);
  endtask

  task automatic t_w1c();
    wr(8'h38, 32'h0000_0200);
    check("R3 partial clear", raw_o, 32'h8000_0004);
    wr(8'h38, 32'hFFFF_FFFF);
    check("R3 clear all", raw_o, '0);
  endtask

  task automatic t_collide();
    pulse(32'h0000_0060);
    @(negedge clk); reg_addr = 8'h38; reg_wdata = 32'h0000_0060; reg_wr = 1'b1;
    evt_i = 32'h0000_0020;
    @(negedge clk); reg_wr = 1'b0; evt_i = '0;
    check("R4 collision keeps set", raw_o, 32'h0000_0020);
    wr(8'h38, 32'hFFFF_FFFF);
  endtask

  task automatic t_unused();
    pulse(32'h3FFE_0001);
    check("R5 unused events", raw_o, '0);
    rd(8'h38, rv); check("R5 unused read", rv, '0);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, rv); check("R6 mask impl", rv, IMPL);
  endtask

  task automatic t_mask_irq();
    wr(8'h30, 32'h0000_0010);
    rd(8'h30, rv); check("R6 mask readback", rv, 32'h0000_0010);
    pulse(32'h0001_0000);
    settle();
    check("R8 irq masked off", {31'd0, irq_o}, 32'd0);
    check("R7 masked zero", masked_o, '0);
    pulse(32'h0000_0010);
    check("R8 irq lag", {31'd0, irq_o}, 32'd0);
    settle();
    check("R8 irq set", {31'd0, irq_o}, 32'd1);
    check("R7 masked", masked_o, 32'h0000_0010);
    rd(8'h34, rv); check("R7 masked read", rv, 32'h0000_0010);
    wr(8'h34, 32'hFFFF_FFFF);
    check("R7 write ignored raw", raw_o, 32'h0001_0010);
    rd(8'h30, rv); check("R7 write ignored mask", rv, 32'h0000_0010);
    wr(8'h38, 32'h0000_0010);
    settle();
    check("R8 irq drops", {31'd0, irq_o}, 32'd0);
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h30, 32'h0);
  endtask

  task automatic t_summary();
    pulse(32'h0000_4000); settle();
    check("R10 acmd done", {30'd0, err_sum_o, done_sum_o}, 32'b01);
    wr(8'h38, 32'hFFFF_FFFF); settle();
    pulse(32'h0000_2000); settle();
    check("R9 start err", {30'd0, err_sum_o, done_sum_o}, 32'b10);
    wr(8'h38, 32'hFFFF_FFFF); settle();
    pulse(32'h0000_0400); settle();
    check("R9 R10 vsw both", {30'd0, err_sum_o, done_sum_o}, 32'b11);
    wr(8'h38, 32'hFFFF_FFFF); settle();
    pulse(32'h4001_0010); settle();
    check("R9 R10 neither", {30'd0, err_sum_o, done_sum_o}, 32'b00);
    check("R8 unmasked no irq", {31'd0, irq_o}, 32'd0);
    wr(8'h38, 32'hFFFF_FFFF); settle();
  endtask

  task automatic t_readmap();
    pulse(32'h0000_0008);
    rd(8'h3C, rv); check("R11 unmapped", rv, '0);
    rd(8'h38, rv); check("R11 raw read", rv, 32'h0000_0008);
    wr(8'h38, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sticky();
    t_w1c();
    t_collide();
    t_unused();
    wr(8'h30, 32'h0);
    t_mask_irq();
    t_summary();
    t_readmap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule